// File: doc/BRIEF.md
# Character-synchronous transparent receive framer

This block sits behind a serial line receiver. It takes one data bit on each clock where a bit enable is high and hunts for character alignment. When it has alignment, it assembles every later group of eight bits into a character. Each character is presented with a one-clock valid strobe.

Alignment comes from one of two sources, chosen by a mode input:

- **Internal mode:** the receiver slides bit by bit until it sees a programmed first sync character. It then requires the programmed second sync character in the very next character slot.
- **External mode:** the receiver is locked by a single-clock pulse on a dedicated input.

No character is ever removed after lock. Sync codes and escape codes arriving as data reach the output unchanged, so the receiver is fully transparent. A second input selects whether serial bits fill a character from its most significant end or from its least significant end. A synchronous restart input drops lock and starts a new hunt.

Top module: `bsr_framer`

## Requirements
- R1: After reset, `sync_locked` and `char_valid` are 0. A clock with `hunt_restart` high drives both to 0 on the next clock.
- R2: In internal mode, the first sync character is found at any bit offset in the serial stream. No prior character alignment is needed.
- R3: In internal mode, the second sync character in the eight bits right after the first one raises `sync_locked` on the clock after its last bit. Every later group of eight bits is then delivered.
- R4: If the eight bits after the first sync character are not the second sync character, there is no lock. If that character equals the first sync character, it counts as a fresh first sync character, so first, first, second still locks.
- R5: In external mode, a high `sync_pulse` locks on the next clock, and pattern matches are ignored. The first bit sampled with `bit_en` on a later clock is the first bit of the first delivered character.
- R6: After lock, characters equal to either sync code, or to any other value, are delivered unchanged and in order. Nothing is stripped.
- R7: With `lsb_first`=0, the first received bit of a character lands in `char_data[7]`. With `lsb_first`=1, it lands in `char_data[0]`. Sync codes are compared against the character as assembled.
- R8: `char_valid` is high for exactly one clock per character, on the clock after the posedge that samples the eighth bit. `char_data` holds that character while `char_valid` is high.
- R9: `sync_locked` stays high until reset or `hunt_restart`. Sync pulses while locked do not disturb character alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hunt_restart | input | 1 | Synchronous request to drop lock and hunt again |
| bit_en | input | 1 | Receive bit enable; `bit_in` is sampled when high |
| bit_in | input | 1 | Serial receive data |
| ext_mode | input | 1 | 1: lock on `sync_pulse`; 0: lock on the programmed pair |
| sync_pulse | input | 1 | External sync strobe |
| lsb_first | input | 1 | Character bit order (see R7) |
| sync_first | input | 8 | First sync character |
| sync_second | input | 8 | Second sync character |
| char_data | output | 8 | Assembled character |
| char_valid | output | 1 | One-clock strobe per character |
| sync_locked | output | 1 | High while character alignment is held |

## Verification
The assertions assume the following about the inputs:

- `ext_mode`, `lsb_first` and both sync codes change only while the receiver is hunting.
- Lock in external mode comes only from a pulse.
- `bit_en` is never high on two consecutive clocks for more than eight bits without a character boundary. This keeps `char_valid` strobes separate.

The stimulus follows these assumptions:

- Configuration changes only right after a restart.
- Gaps of zero to two idle clocks are inserted between bits at random.
- Hunt prefixes use the fixed codes 0x3C and 0xA5, chosen so that no stray window can match the first sync character.
- The random rounds draw payload freely only after lock, where any value must pass through.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT_BIT  = 2'd0,
    ST_HUNT_PAIR = 2'd1,
    ST_LOCKED    = 2'd2
  } bsr_state_t;
endpackage

// File: rtl/bsr_shift.sv
module bsr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         lsb_first,
  output logic [W-1:0] win_nx
);
  logic [W-1:0] win;

  always_comb begin
    if (lsb_first) win_nx = {bit_in, win[W-1:1]};
    else           win_nx = {win[W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    win <= '0;
    else if (shift_en) win <= win_nx;
  end
endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         bit_en,
  input  logic         ext_mode,
  input  logic         ext_pulse,
  input  logic [W-1:0] win_nx,
  input  logic [W-1:0] syn1,
  input  logic [W-1:0] syn2,
  output logic         locked,
  output logic         char_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bsr_state_t state;
  logic [CW-1:0] cnt;

  assign locked    = (state == ST_LOCKED);
  assign char_done = locked && bit_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state <= ST_HUNT_BIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_HUNT_BIT: begin
          cnt <= '0;
          if (ext_mode) begin
            if (ext_pulse) state <= ST_LOCKED;
          end else if (bit_en && win_nx == syn1) begin
            state <= ST_HUNT_PAIR;
          end
        end
        ST_HUNT_PAIR: begin
          if (ext_mode) begin
            state <= ST_HUNT_BIT;
            cnt   <= '0;
          end else if (bit_en) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (win_nx == syn2)      state <= ST_LOCKED;
              else if (win_nx != syn1) state <= ST_HUNT_BIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (bit_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
        default: begin
          state <= ST_HUNT_BIT;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R9: lock is held until restart
  assert_lock_held_R9: assert property (@(posedge clk) disable iff (rst)
    locked && !restart |=> locked);
  // R1: restart drops lock
  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (rst)
    restart |=> !locked);
  // R5: in external mode lock only follows a pulse
  assert_ext_lock_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) && ext_mode |-> $past(ext_pulse));
  // R3: in internal mode lock only follows a sampled bit
  assert_int_lock_on_bit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) && !ext_mode |-> $past(bit_en));
endmodule

// File: rtl/bsr_framer.sv
module bsr_framer #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hunt_restart,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              ext_mode,
  input  logic              sync_pulse,
  input  logic              lsb_first,
  input  logic [CHAR_W-1:0] sync_first,
  input  logic [CHAR_W-1:0] sync_second,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  output logic              sync_locked
);
  logic [CHAR_W-1:0] win_nx;
  logic              char_done;

  bsr_shift #(.W(CHAR_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (hunt_restart),
    .shift_en (bit_en),
    .bit_in   (bit_in),
    .lsb_first(lsb_first),
    .win_nx   (win_nx)
  );

  bsr_seq #(.W(CHAR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .restart  (hunt_restart),
    .bit_en   (bit_en),
    .ext_mode (ext_mode),
    .ext_pulse(sync_pulse),
    .win_nx   (win_nx),
    .syn1     (sync_first),
    .syn2     (sync_second),
    .locked   (sync_locked),
    .char_done(char_done)
  );

  always_ff @(posedge clk) begin
    if (rst || hunt_restart) begin
      char_valid <= 1'b0;
      char_data  <= '0;
    end else begin
      char_valid <= char_done;
      if (char_done) char_data <= win_nx;
    end
  end

  // R8: one-clock strobe per character
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);
  // R6: characters only flow while locked
  assert_valid_needs_lock_R6: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> sync_locked);
endmodule

// File: tb/test_bsr_framer.sv
module test_bsr_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hunt_restart = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic ext_mode = 1'b0, sync_pulse = 1'b0, lsb_first = 1'b0;
  logic [7:0] sync_first = 8'h3C, sync_second = 8'hA5;
  logic [7:0] char_data;
  logic char_valid, sync_locked;

  int n_cmp = 0, n_bad = 0;
  bit prev_valid = 0;
  logic [7:0] rxq[$];
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  bsr_framer i_bsr_framer (
    .clk(clk), .rst(rst), .hunt_restart(hunt_restart), .bit_en(bit_en),
    .bit_in(bit_in), .ext_mode(ext_mode), .sync_pulse(sync_pulse),
    .lsb_first(lsb_first), .sync_first(sync_first), .sync_second(sync_second),
    .char_data(char_data), .char_valid(char_valid), .sync_locked(sync_locked)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: capture delivered characters, check strobe width (R8)
  always @(negedge clk) begin
    if (!rst && char_valid) begin
      rxq.push_back(char_data);
      if (prev_valid) chk(1'b0, "R8 valid wider than one clock", 1, 0);
    end
    prev_valid = char_valid;
  end

  bit rand_gap = 0;

  task automatic send_bit(logic b);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    if (rand_gap) repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic send_char(logic [7:0] c, bit deliver);
    for (int i = 0; i < 8; i++) send_bit(lsb_first ? c[i] : c[7-i]);
    if (deliver) expq.push_back(c);
  endtask

  task automatic pulse_sync();
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
  endtask

  task automatic restart();
    hunt_restart = 1'b1;
    @(negedge clk);
    hunt_restart = 1'b0;
  endtask

  task automatic check_rx(string req);
    repeat (2) @(negedge clk);
    chk(rxq.size() == expq.size(), {req, " count"}, rxq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      chk(rxq[i] == expq[i], {req, " data"}, rxq[i], expq[i]);
    rxq.delete();
    expq.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sync_locked == 1'b0, "R1 locked after reset", sync_locked, 0);
    chk(char_valid == 1'b0, "R1 valid after reset", char_valid, 0);

    // R2/R3/R6: internal mode, odd bit offset, MSB first
    send_bit(1); send_bit(0); send_bit(1);
    send_char(8'h3C, 0);
    chk(sync_locked == 1'b0, "R3 no lock before second sync", sync_locked, 0);
    send_char(8'hA5, 0);
    @(negedge clk);
    chk(sync_locked == 1'b1, "R2 R3 lock after pair at offset 3", sync_locked, 1);
    send_char(8'h3C, 1); send_char(8'hA5, 1); send_char(8'h10, 1); send_char(8'hFF, 1);
    check_rx("R6 transparent delivery");

    // R9: restart drops lock
    restart();
    chk(sync_locked == 1'b0, "R9 restart clears lock", sync_locked, 0);
    chk(char_valid == 1'b0, "R1 restart clears valid", char_valid, 0);

    // R4: first sync then wrong char -> no lock
    send_char(8'h3C, 0); send_char(8'h11, 0); send_char(8'hA5, 0);
    @(negedge clk);
    chk(sync_locked == 1'b0, "R4 broken pair does not lock", sync_locked, 0);
    check_rx("R4 nothing delivered while hunting");
    restart();
    send_char(8'h3C, 0); send_char(8'h3C, 0); send_char(8'hA5, 0);
    @(negedge clk);
    chk(sync_locked == 1'b1, "R4 repeated first sync locks", sync_locked, 1);
    send_char(8'h5A, 1);
    check_rx("R4 data after repeated sync");

    // R7: bit order, raw bits 1,0,0,0,0,0,0,0
    restart();
    lsb_first = 1'b0;
    send_char(8'h3C, 0); send_char(8'hA5, 0);
    send_bit(1); for (int i = 0; i < 7; i++) send_bit(0);
    expq.push_back(8'h80);
    check_rx("R7 msb-first first bit in bit 7");
    restart();
    lsb_first = 1'b1;
    send_char(8'h3C, 0); send_char(8'hA5, 0);
    send_bit(1); for (int i = 0; i < 7; i++) send_bit(0);
    expq.push_back(8'h01);
    check_rx("R7 lsb-first first bit in bit 0");

    // R5: external mode ignores pattern, locks on pulse
    restart();
    ext_mode = 1'b1;
    lsb_first = 1'b0;
    send_char(8'h3C, 0); send_char(8'hA5, 0);
    @(negedge clk);
    chk(sync_locked == 1'b0, "R5 pattern ignored in external mode", sync_locked, 0);
    check_rx("R5 nothing before pulse");
    pulse_sync();
    chk(sync_locked == 1'b1, "R5 pulse locks", sync_locked, 1);
    send_char(8'hC3, 1);
    // R9: pulse mid-character must not realign
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    pulse_sync();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    expq.push_back(8'h0F);
    send_char(8'h96, 1);
    chk(sync_locked == 1'b1, "R9 lock held through pulse", sync_locked, 1);
    check_rx("R5 R9 external delivery");

    // random rounds with idle gaps
    rand_gap = 1;
    for (int r = 0; r < 24; r++) begin
      restart();
      ext_mode = r[0];
      lsb_first = $urandom_range(0, 1);
      if (ext_mode) begin
        for (int j = 0; j < $urandom_range(0, 2); j++) send_char(8'($urandom), 0);
        pulse_sync();
      end else begin
        send_char(8'h3C, 0);
        send_char(8'hA5, 0);
      end
      for (int j = 0; j < 4; j++) send_char(8'($urandom), 1);
      chk(sync_locked == 1'b1, "R3 R5 random lock", sync_locked, 1);
      check_rx("R6 R8 random payload");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule